// File: doc/BRIEF.md
# Qualified Programmable Event Counter

This block is one programmable performance-monitoring counter. Every cycle it looks at a small set of event lanes, each reporting whether an event happened, which 8-bit event code it carries, and an 8-bit attribute byte. The attribute byte describes the line state in its low nibble and the request type in its high nibble. A configuration word picks one event code and an 8-bit selection mask. Each cycle the block counts the lanes that match. If the selected code is the occupancy code, it takes the level of an outstanding-request tracker instead of the lane count.

Three qualifiers then reshape that per-cycle number before it reaches a 48-bit accumulator. A threshold turns the count into a yes/no comparison. An invert flag flips that comparison. An edge flag counts only rising transitions of the condition. Software reaches the configuration, the counter and a sticky wrap flag through a small register port. Writes take effect on the clock edge. Reads are combinational.

Top module: `evc_counter`

## Requirements
- R1: A lane matches when its valid bit is set, its code equals the selected code, and its state nibble (attribute bits 3:0) shares a set bit with mask bits 3:0. Several state bits in the mask are OR-combined. With threshold zero and no edge flag, the counter adds the number of matching lanes each cycle.
- R2: Mask bits 7:4 are request-type filters. When any of them is set, a lane also needs a common set bit between its attribute bits 7:4 and mask bits 7:4. A mask whose bits 3:0 are all zero matches nothing.
- R3: With a nonzero threshold and the invert flag clear, the counter adds one in each cycle whose per-cycle count is at least the threshold, and adds nothing in other cycles.
- R4: With a nonzero threshold and the invert flag set, the counter adds one in each cycle whose per-cycle count is below the threshold.
- R5: With the edge flag set, the counter adds one only on a false-to-true change of the condition. The condition is "count nonzero" when the threshold is zero. The remembered condition is cleared while disabled and on every configuration write, so the first true cycle after either of these counts.
- R6: When the selected code equals the occupancy code (80h by default), the per-cycle count is the value on `occ_level` and the lanes are ignored.
- R7: Register select 0 is the configuration word: code in bits 7:0, mask in bits 15:8, threshold in bits 23:16, invert in bit 24, edge in bit 25, enable in bit 26. Select 1 is the 48-bit counter and is readable and writable. Select 2 reads the wrap flag in bit 0 and ignores writes.
- R8: A configuration write governs counting from the following cycle on. A counter write loads the written value exactly and overrides any increment in the same cycle.
- R9: The counter wraps modulo 2^48. A wrap sets the sticky wrap flag, which stays set until the next counter write clears it.
- R10: While the enable bit is clear, the counter does not change except through writes.
- R11: After reset, the configuration, the counter and the wrap flag all read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register selected for writing |
| wr_data | input | 48 | Write data |
| rd_sel | input | 2 | Register selected for reading |
| rd_data | output | 48 | Read data (combinational) |
| lane_vld | input | 4 | Per-lane event-occurred flag |
| lane_code | input | 32 | Per-lane event code, 8 bits per lane, lane 0 lowest |
| lane_attr | input | 32 | Per-lane attribute byte: state nibble low, request type high |
| occ_level | input | 6 | Outstanding-request tracker level |

## Verification
The bench probes several failure modes, and each has a visible symptom:
- **Filter mask with no state bit.** A design that forgets this rule counts every type-matching lane instead of nothing.
- **Edge re-arm.** Holding the condition true across a disable and a re-enable must give a second count. A design that keeps the old remembered condition would stay one short.
- **Write during active counting.** A counter write in a cycle with active events must read back unchanged. Letting the increment win would leave the value off by the occupancy level.
- **Wrap below 2^48.** Starting two below the limit must give a small residue and set the sticky flag. The flag must survive later cycles and clear only on a counter write.
- **Configuration timing.** Events present during a configuration write must not be counted. This exposes a design that applies the new configuration one cycle early.

// File: rtl/evc_pkg.sv
package evc_pkg;

    localparam int CODE_W  = 8;
    localparam int MASK_W  = 8;
    localparam int STATE_W = 4;
    localparam int THR_W   = 8;
    localparam int CFG_W   = CODE_W + MASK_W + THR_W + 3;

    typedef enum logic [1:0] {
        SEL_CFG  = 2'd0,
        SEL_CNT  = 2'd1,
        SEL_STAT = 2'd2,
        SEL_RSVD = 2'd3
    } reg_sel_e;

    // first member is the most significant field
    typedef struct packed {
        logic              enable;
        logic              edge_det;
        logic              invert;
        logic [THR_W-1:0]  thresh;
        logic [MASK_W-1:0] umask;
        logic [CODE_W-1:0] code;
    } evc_cfg_t;

    // state nibble is OR-selected; filter nibble qualifies only when nonzero
    function automatic logic sub_event_hit(input logic [MASK_W-1:0] mask,
                                           input logic [MASK_W-1:0] attr);
        logic [STATE_W-1:0]        st_m;
        logic [MASK_W-STATE_W-1:0] flt_m;
        st_m  = mask[STATE_W-1:0];
        flt_m = mask[MASK_W-1:STATE_W];
        return ((attr[STATE_W-1:0] & st_m) != '0) &&
               ((flt_m == '0) || ((attr[MASK_W-1:STATE_W] & flt_m) != '0));
    endfunction

endpackage

// File: rtl/evc_match.sv
module evc_match #(
    parameter int NUM_LANES = 4,
    parameter int OCC_W     = 6,
    parameter int NW        = 6,
    parameter logic [evc_pkg::CODE_W-1:0] OCC_CODE = 8'h80
) (
    input  logic [evc_pkg::CODE_W-1:0]           sel_code,
    input  logic [evc_pkg::MASK_W-1:0]           sel_mask,
    input  logic [NUM_LANES-1:0]                 lane_vld,
    input  logic [NUM_LANES*evc_pkg::CODE_W-1:0] lane_code,
    input  logic [NUM_LANES*evc_pkg::MASK_W-1:0] lane_attr,
    input  logic [OCC_W-1:0]                     occ_level,
    output logic [NW-1:0]                        ev_count
);
    import evc_pkg::*;

    logic [NUM_LANES-1:0] hit;
    logic [NW-1:0]        lane_sum;

    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
        assign hit[i] = lane_vld[i]
                     && (lane_code[i*CODE_W +: CODE_W] == sel_code)
                     && sub_event_hit(sel_mask, lane_attr[i*MASK_W +: MASK_W]);
    end

    always_comb begin
        lane_sum = '0;
        for (int i = 0; i < NUM_LANES; i++) begin
            lane_sum = lane_sum + NW'(hit[i]);
        end
        if (sel_code == OCC_CODE) begin
            ev_count = NW'(occ_level);
        end else begin
            ev_count = lane_sum;
        end
    end

endmodule

// File: rtl/evc_qualify.sv
module evc_qualify #(
    parameter int NW = 6
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      enable,
    input  logic                      clear,
    input  logic [evc_pkg::THR_W-1:0] thresh,
    input  logic                      invert,
    input  logic                      edge_det,
    input  logic [NW-1:0]             ev_count,
    output logic [NW-1:0]             inc
);
    import evc_pkg::*;

    localparam int CMP_W = (NW > THR_W) ? NW : THR_W;

    logic [CMP_W-1:0] cnt_x;
    logic [CMP_W-1:0] thr_x;
    logic             thr_on;
    logic             cond;
    logic             prev_q;

    assign cnt_x  = CMP_W'(ev_count);
    assign thr_x  = CMP_W'(thresh);
    assign thr_on = (thresh != '0);

    always_comb begin
        if (thr_on) begin
            cond = invert ? (cnt_x < thr_x) : (cnt_x >= thr_x);
        end else begin
            cond = (ev_count != '0);
        end
        if (edge_det) begin
            inc = NW'(cond && !prev_q);
        end else if (thr_on) begin
            inc = NW'(cond);
        end else begin
            inc = ev_count;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear || !enable) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= cond;
        end
    end

endmodule

// File: rtl/evc_accum.sv
module evc_accum #(
    parameter int CNT_W = 48,
    parameter int NW    = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic [NW-1:0]    inc,
    input  logic             wr_cnt,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] cnt_q,
    output logic             ovf_q
);
    logic [CNT_W:0] sum;

    assign sum = {1'b0, cnt_q} + (CNT_W+1)'(inc);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else if (wr_cnt) begin
            cnt_q <= wr_data;
            ovf_q <= 1'b0;
        end else if (enable) begin
            cnt_q <= sum[CNT_W-1:0];
            if (sum[CNT_W]) begin
                ovf_q <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/evc_counter.sv
module evc_counter #(
    parameter int NUM_LANES = 4,
    parameter int OCC_W     = 6,
    parameter int CNT_W     = 48,
    parameter logic [7:0] OCC_CODE = 8'h80
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           wr_en,
    input  logic [1:0]                     wr_sel,
    input  logic [CNT_W-1:0]               wr_data,
    input  logic [1:0]                     rd_sel,
    output logic [CNT_W-1:0]               rd_data,
    input  logic [NUM_LANES-1:0]           lane_vld,
    input  logic [NUM_LANES*8-1:0]         lane_code,
    input  logic [NUM_LANES*8-1:0]         lane_attr,
    input  logic [OCC_W-1:0]               occ_level
);
    import evc_pkg::*;

    localparam int LANE_CW = $clog2(NUM_LANES + 1);
    localparam int NW      = (OCC_W > LANE_CW) ? OCC_W : LANE_CW;

    evc_cfg_t         cfg_q;
    logic             wr_cfg;
    logic             wr_cnt;
    logic [NW-1:0]    ev_count;
    logic [NW-1:0]    inc;
    logic [CNT_W-1:0] cnt_q;
    logic             ovf_q;

    assign wr_cfg = wr_en && (wr_sel == SEL_CFG);
    assign wr_cnt = wr_en && (wr_sel == SEL_CNT);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (wr_cfg) begin
            cfg_q <= evc_cfg_t'(wr_data[CFG_W-1:0]);
        end
    end

    evc_match #(
        .NUM_LANES (NUM_LANES),
        .OCC_W     (OCC_W),
        .NW        (NW),
        .OCC_CODE  (OCC_CODE)
    ) u_match (
        .sel_code  (cfg_q.code),
        .sel_mask  (cfg_q.umask),
        .lane_vld  (lane_vld),
        .lane_code (lane_code),
        .lane_attr (lane_attr),
        .occ_level (occ_level),
        .ev_count  (ev_count)
    );

    evc_qualify #(
        .NW (NW)
    ) u_qual (
        .clk      (clk),
        .rst      (rst),
        .enable   (cfg_q.enable),
        .clear    (wr_cfg),
        .thresh   (cfg_q.thresh),
        .invert   (cfg_q.invert),
        .edge_det (cfg_q.edge_det),
        .ev_count (ev_count),
        .inc      (inc)
    );

    evc_accum #(
        .CNT_W (CNT_W),
        .NW    (NW)
    ) u_acc (
        .clk     (clk),
        .rst     (rst),
        .enable  (cfg_q.enable),
        .inc     (inc),
        .wr_cnt  (wr_cnt),
        .wr_data (wr_data),
        .cnt_q   (cnt_q),
        .ovf_q   (ovf_q)
    );

    always_comb begin
        case (rd_sel)
            SEL_CFG:  rd_data = CNT_W'(cfg_q);
            SEL_CNT:  rd_data = cnt_q;
            SEL_STAT: rd_data = CNT_W'(ovf_q);
            default:  rd_data = '0;
        endcase
    end

endmodule

// File: rtl/evc_counter_chk.sv
module evc_counter_chk #(
    parameter int CNT_W = 48,
    parameter int NW    = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [1:0]       wr_sel,
    input logic [CNT_W-1:0] wr_data,
    input logic [CNT_W-1:0] cnt_q,
    input logic             ovf_q,
    input logic             cfg_en,
    input logic             cfg_edge,
    input logic [7:0]       cfg_thr,
    input logic [NW-1:0]    inc
);
    logic cnt_wr;
    logic cfg_wr;
    assign cnt_wr = wr_en && (wr_sel == 2'd1);
    assign cfg_wr = wr_en && (wr_sel == 2'd0);

    a_r8_write_wins: assert property (@(posedge clk) disable iff (rst)
        cnt_wr |=> (cnt_q == $past(wr_data)));

    a_r10_disabled_hold: assert property (@(posedge clk) disable iff (rst)
        (!cfg_en && !cnt_wr) |=> (cnt_q == $past(cnt_q)));

    a_r5_single_edge: assert property (@(posedge clk) disable iff (rst)
        (cfg_en && cfg_edge && (inc != '0) && !cfg_wr) |=> (inc == '0));

    a_r3_step_le_one: assert property (@(posedge clk) disable iff (rst)
        (cfg_en && (cfg_thr != '0) && !cnt_wr && !cfg_wr)
        |=> ((cnt_q == $past(cnt_q)) || (cnt_q == CNT_W'($past(cnt_q) + 1'b1))));

    a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        (ovf_q && !cnt_wr) |=> ovf_q);

    a_r9_ovf_clear: assert property (@(posedge clk) disable iff (rst)
        cnt_wr |=> !ovf_q);

endmodule

bind evc_counter evc_counter_chk #(
    .CNT_W (CNT_W),
    .NW    (NW)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .cnt_q    (cnt_q),
    .ovf_q    (ovf_q),
    .cfg_en   (cfg_q.enable),
    .cfg_edge (cfg_q.edge_det),
    .cfg_thr  (cfg_q.thresh),
    .inc      (inc)
);

// File: tb/evc_counter_tb_top.sv
module evc_counter_tb_top;

    typedef struct packed {
        logic [7:0]  code;
        logic [7:0]  mask;
        logic [7:0]  thr;
        logic        inv;
        logic        edg;
        logic        en;
        logic [3:0]  vld;
        logic [5:0]  occ;
        logic [15:0] exp3;
        logic [7:0]  req;
    } vec_t;

    // each vector holds its stimulus for three cycles; exp3 is the total
    localparam vec_t VECS [13] = '{
        '{8'h34, 8'h06, 8'd0, 1'b0, 1'b0, 1'b1, 4'hF, 6'd0, 16'd6,  8'd1},  // R1 OR of two states
        '{8'h34, 8'h1F, 8'd0, 1'b0, 1'b0, 1'b1, 4'hF, 6'd0, 16'd6,  8'd2},  // R2 type filter
        '{8'h34, 8'h10, 8'd0, 1'b0, 1'b0, 1'b1, 4'hF, 6'd0, 16'd0,  8'd2},  // R2 no state bit
        '{8'h34, 8'h0F, 8'd3, 1'b0, 1'b0, 1'b1, 4'hF, 6'd0, 16'd3,  8'd3},  // R3 at threshold
        '{8'h34, 8'h0F, 8'd4, 1'b0, 1'b0, 1'b1, 4'hF, 6'd0, 16'd0,  8'd3},  // R3 below threshold
        '{8'h34, 8'h0F, 8'd4, 1'b1, 1'b0, 1'b1, 4'hF, 6'd0, 16'd3,  8'd4},  // R4 inverted
        '{8'h34, 8'h0F, 8'd2, 1'b0, 1'b1, 1'b1, 4'hF, 6'd0, 16'd1,  8'd5},  // R5 held condition
        '{8'h22, 8'h01, 8'd0, 1'b0, 1'b0, 1'b1, 4'hF, 6'd0, 16'd3,  8'd1},  // R1 other code
        '{8'h80, 8'h00, 8'd0, 1'b0, 1'b0, 1'b1, 4'hF, 6'd5, 16'd15, 8'd6},  // R6 weighted
        '{8'h80, 8'h00, 8'd5, 1'b0, 1'b0, 1'b1, 4'hF, 6'd5, 16'd3,  8'd6},  // R6 with threshold
        '{8'h34, 8'h0F, 8'd0, 1'b0, 1'b1, 1'b1, 4'hF, 6'd0, 16'd1,  8'd5},  // R5 zero threshold
        '{8'h34, 8'h0F, 8'd0, 1'b0, 1'b0, 1'b0, 4'hF, 6'd0, 16'd0,  8'd10}, // R10 disabled
        '{8'h34, 8'h0F, 8'd0, 1'b0, 1'b0, 1'b1, 4'h5, 6'd0, 16'd3,  8'd1}   // R1 partial valid
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [47:0] wr_data = '0;
    logic [1:0]  rd_sel = 2'd0;
    logic [47:0] rd_data;
    logic [3:0]  lane_vld = '0;
    logic [31:0] lane_code = {8'h34, 8'h34, 8'h34, 8'h22};
    logic [31:0] lane_attr = {8'h18, 8'h24, 8'h12, 8'h01};
    logic [5:0]  occ_level = '0;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    evc_counter dut_i (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .rd_sel    (rd_sel),
        .rd_data   (rd_data),
        .lane_vld  (lane_vld),
        .lane_code (lane_code),
        .lane_attr (lane_attr),
        .occ_level (occ_level)
    );

    function automatic logic [47:0] mk_cfg(input logic [7:0] code, input logic [7:0] mask,
                                           input logic [7:0] thr, input logic inv,
                                           input logic edg, input logic en);
        return {21'd0, en, edg, inv, thr, mask, code};
    endfunction

    task automatic chk(input string tag, input logic [47:0] act, input logic [47:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // called at a falling edge; occupies exactly one rising edge
    task automatic reg_write(input logic [1:0] sel, input logic [47:0] data);
        wr_en   = 1'b1;
        wr_sel  = sel;
        wr_data = data;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] sel, output logic [47:0] val);
        rd_sel = sel;
        #1;
        val = rd_data;
    endtask

    task automatic stim_off();
        lane_vld  = '0;
        occ_level = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL R11 watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [47:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R11 reset values
        reg_read(2'd0, v); chk("R11 cfg after reset", v, 48'd0);
        reg_read(2'd1, v); chk("R11 counter after reset", v, 48'd0);
        reg_read(2'd2, v); chk("R11 wrap flag after reset", v, 48'd0);

        // vector table
        for (int i = 0; i < 13; i++) begin
            reg_write(2'd0, 48'd0);
            reg_write(2'd1, 48'd0);
            reg_write(2'd0, mk_cfg(VECS[i].code, VECS[i].mask, VECS[i].thr,
                                   VECS[i].inv, VECS[i].edg, VECS[i].en));
            lane_vld  = VECS[i].vld;
            occ_level = VECS[i].occ;
            repeat (3) @(negedge clk);
            stim_off();
            reg_read(2'd1, v);
            chk($sformatf("R%0d vector %0d", VECS[i].req, i), v, 48'(VECS[i].exp3));
        end

        // R7 config readback
        reg_read(2'd0, v);
        chk("R7 config readback", v, mk_cfg(8'h34, 8'h0F, 8'd0, 1'b0, 1'b0, 1'b1));

        // R5 re-arm after disable/reconfigure with condition held true
        reg_write(2'd0, 48'd0);
        reg_write(2'd1, 48'd0);
        reg_write(2'd0, mk_cfg(8'h34, 8'h0F, 8'd2, 1'b0, 1'b1, 1'b1));
        lane_vld = 4'hF;
        @(negedge clk);
        reg_write(2'd0, mk_cfg(8'h34, 8'h0F, 8'd2, 1'b0, 1'b1, 1'b0));
        reg_write(2'd0, mk_cfg(8'h34, 8'h0F, 8'd2, 1'b0, 1'b1, 1'b1));
        repeat (2) @(negedge clk);
        reg_read(2'd1, v); chk("R5 re-armed after disable", v, 48'd2);
        lane_vld = 4'h0;
        @(negedge clk);
        lane_vld = 4'hF;
        @(negedge clk);
        stim_off();
        reg_read(2'd1, v); chk("R5 false then true edge", v, 48'd3);

        // R8 config takes effect the cycle after the write
        reg_write(2'd0, 48'd0);
        reg_write(2'd1, 48'd0);
        occ_level = 6'd5;
        reg_write(2'd0, mk_cfg(8'h80, 8'h00, 8'd0, 1'b0, 1'b0, 1'b1));
        reg_read(2'd1, v); chk("R8 no count in config write cycle", v, 48'd0);
        @(negedge clk);
        reg_read(2'd1, v); chk("R8 count after config write", v, 48'd5);

        // R8 counter write beats a same-cycle increment
        reg_write(2'd1, 48'd1000);
        reg_read(2'd1, v); chk("R8 write wins over increment", v, 48'd1000);
        @(negedge clk);
        reg_read(2'd1, v); chk("R8 counting resumes", v, 48'd1005);
        stim_off();

        // R9 wrap and sticky flag
        reg_write(2'd0, 48'd0);
        reg_write(2'd1, 48'hFFFF_FFFF_FFFE);
        reg_write(2'd0, mk_cfg(8'h80, 8'h00, 8'd0, 1'b0, 1'b0, 1'b1));
        occ_level = 6'd5;
        @(negedge clk);
        stim_off();
        reg_read(2'd1, v); chk("R9 wrapped value", v, 48'd3);
        reg_read(2'd2, v); chk("R9 wrap flag set", v, 48'd1);
        reg_write(2'd0, 48'd0);
        repeat (2) @(negedge clk);
        reg_read(2'd2, v); chk("R9 wrap flag sticky", v, 48'd1);

        // R7 status register ignores writes
        reg_write(2'd2, 48'd0);
        reg_read(2'd2, v); chk("R7 status write ignored", v, 48'd1);

        reg_write(2'd1, 48'd7);
        reg_read(2'd2, v); chk("R9 wrap flag cleared by counter write", v, 48'd0);
        reg_read(2'd1, v); chk("R7 counter write readback", v, 48'd7);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule